// File: doc/BRIEF.md
# DMA Control Register Bank

This block is the control-register front end of a four-channel DMA controller. A byte-wide register bus (write strobe, read strobe, address, data) reaches eight control ports. The port index is the address shifted right by a build-time shift amount, then cut to four bits. That lets the bank sit on buses whose registers are spaced one, two or more bytes apart.

Writes and reads decode to different registers. The write side holds:
- the command byte, which refuses unsupported settings;
- four software request bits;
- the four channel masks;
- a mode field for each channel;
- the byte-pointer flip-flop.

Some write ports carry no data and act as strobes: pointer clear, master clear and clear-all-masks. The read side returns status or the mask. Reading status clears its terminal-count nibble and keeps the request nibble.

The transfer engine reports the end of a transfer with terminal-count pulses. The channel address/count logic toggles the byte pointer. Any write that can change the masks or requests sends a one-cycle wake pulse to the channel arbiter.

Top module: `dmac_ctl_bank`

## Requirements
- R1: Synchronous reset (rst high) gives all four masks set (chan_mask = 4'hF), status 8'h00, cmd_q 8'h00, ptr_ff 0, every mode field 0 and reeval 0.
- R2: The port index is (addr >> PORT_SHIFT) & 4'hF, with PORT_SHIFT = 1 by default. Address bits below the shift and above the index are ignored. Writes to indices 8 to 15 change no state and raise no reeval.
- R3: A write to index 0 loads cmd_q from wdata, unless wdata is nonzero and shares a bit with CMD_REJECT (default 8'hF0). A rejected write leaves cmd_q unchanged.
- R4: A write to index 1 picks channel wdata[1:0]. It sets request status bit (4 + channel) when wdata[2] = 1 and clears that bit when wdata[2] = 0.
- R5: A write to index 2 sets chan_mask[wdata[1:0]] when wdata[2] = 1 and clears it when wdata[2] = 0. The other channels keep their masks.
- R6: A write to index 3 loads wdata[7:2] into the 6-bit mode field of channel wdata[1:0]. Channel c occupies mode_q[6c+5:6c].
- R7: ff_toggle inverts ptr_ff. A write to index 4 clears ptr_ff whatever the data, and the clear wins over a toggle in the same cycle.
- R8: A write to index 5 (master clear) sets every mask, and zeroes ptr_ff, cmd_q and the whole status byte.
- R9: A write to index 6 clears every mask. A write to index 7 loads the masks from wdata[3:0].
- R10: reeval is high for exactly the one cycle after the edge that takes a write to index 1, 2, 5, 6 or 7. It stays low after writes to any other index.
- R11: While rd_en is high at index 0, rdata is the status byte: request bits in [7:4], terminal-count bits in [3:0]. At that edge the terminal-count nibble clears and the request nibble is kept.
- R12: While rd_en is high at index 1, rdata is {4'h0, chan_mask}. Reads at every other index return 8'hFF.
- R13: tc_pulse[c] sets status bit c. A set arriving in the same cycle as a status read-clear survives the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Bus address, port index taken after the shift |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| tc_pulse | input | 4 | Per-channel terminal-count pulse from the transfer engine |
| ff_toggle | input | 1 | Byte-pointer toggle from the address/count logic |
| chan_mask | output | 4 | Per-channel mask, 1 = masked |
| reeval | output | 1 | One-cycle arbiter wake pulse |
| cmd_q | output | 8 | Command register |
| mode_q | output | 24 | Mode fields, 6 bits per channel |
| ptr_ff | output | 1 | Byte-pointer flip-flop |

## Verification
The mask logic is driven with single-channel set and clear, set-all, clear-all and load-all patterns. This separates per-channel indexing from whole-register updates, and shows that setting an already-set bit is harmless. Command writes use an accepted value, a rejected value and zero, which isolates the reject rule from plain loading. Status is exercised by request writes through both a plain and an aliased address, back-to-back reads, and a terminal-count pulse that lands on the read-clear edge. Together these show which nibble survives a read and which event wins a collision. Writes to unused indices, and to ports that carry no data, confirm that only the intended state moves and that the wake pulse follows the right ports.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;

    localparam int NUM_CH  = 4;
    localparam int BYTE_W  = 8;
    localparam int MODE_W  = 6;
    localparam int IDX_W   = 4;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CMD,
        OP_REQ,
        OP_SMASK,
        OP_MODE,
        OP_CLRFF,
        OP_MCLR,
        OP_CLRMASK,
        OP_WRMASK
    } wr_op_e;

    typedef enum logic [1:0] {
        RD_NONE,
        RD_STATUS,
        RD_MASK,
        RD_OPEN
    } rd_op_e;

    typedef struct packed {
        logic       set;
        logic [1:0] ch;
    } chan_sel_t;

    function automatic chan_sel_t chan_sel(input logic [BYTE_W-1:0] d);
        chan_sel_t s;
        s.set = d[2];
        s.ch  = d[1:0];
        return s;
    endfunction

    function automatic logic wakes_arbiter(input wr_op_e op);
        return (op == OP_REQ) || (op == OP_SMASK) || (op == OP_MCLR) ||
               (op == OP_CLRMASK) || (op == OP_WRMASK);
    endfunction

endpackage

// File: rtl/dmac_port_decode.sv
module dmac_port_decode
    import dmac_ctl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PORT_SHIFT = 1
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    output wr_op_e            wr_op,
    output rd_op_e            rd_op
);

    logic [IDX_W-1:0] idx;

    assign idx = IDX_W'(addr >> PORT_SHIFT);

    always_comb begin
        wr_op = OP_NONE;
        if (wr_en) begin
            case (idx)
                4'd0:    wr_op = OP_CMD;
                4'd1:    wr_op = OP_REQ;
                4'd2:    wr_op = OP_SMASK;
                4'd3:    wr_op = OP_MODE;
                4'd4:    wr_op = OP_CLRFF;
                4'd5:    wr_op = OP_MCLR;
                4'd6:    wr_op = OP_CLRMASK;
                4'd7:    wr_op = OP_WRMASK;
                default: wr_op = OP_NONE;
            endcase
        end
    end

    always_comb begin
        rd_op = RD_NONE;
        if (rd_en) begin
            case (idx)
                4'd0:    rd_op = RD_STATUS;
                4'd1:    rd_op = RD_MASK;
                default: rd_op = RD_OPEN;
            endcase
        end
    end

endmodule

// File: rtl/dmac_mask_reg.sv
module dmac_mask_reg
    import dmac_ctl_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_op_e        wr_op,
    input  chan_sel_t     sel,
    input  logic [CH-1:0] load,
    output logic [CH-1:0] mask_q
);

    always_ff @(posedge clk) begin
        if (rst || wr_op == OP_MCLR) begin
            mask_q <= '1;
        end else begin
            case (wr_op)
                OP_SMASK:   mask_q[sel.ch] <= sel.set;
                OP_CLRMASK: mask_q         <= '0;
                OP_WRMASK:  mask_q         <= load;
                default:    mask_q         <= mask_q;
            endcase
        end
    end

    AST_MCLR_ALL_MASKED: assert property (@(posedge clk) disable iff (rst)
        (wr_op == OP_MCLR) |=> (mask_q == '1)); // R8

    AST_CLRALL_EMPTY: assert property (@(posedge clk) disable iff (rst)
        (wr_op == OP_CLRMASK) |=> (mask_q == '0)); // R9

    AST_SMASK_OTHERS_KEPT: assert property (@(posedge clk) disable iff (rst)
        (wr_op == OP_SMASK) |=>
        ((mask_q & ~(CH'(1) << $past(sel.ch))) ==
         ($past(mask_q) & ~(CH'(1) << $past(sel.ch))))); // R5

endmodule

// File: rtl/dmac_status_reg.sv
module dmac_status_reg
    import dmac_ctl_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic            clk,
    input  logic            rst,
    input  wr_op_e          wr_op,
    input  chan_sel_t       sel,
    input  logic            rd_clr,
    input  logic [CH-1:0]   tc_in,
    output logic [2*CH-1:0] status_q
);

    logic [CH-1:0] req_q;
    logic [CH-1:0] tc_q;
    logic [CH-1:0] tc_base;

    assign status_q = {req_q, tc_q};
    assign tc_base  = (rd_clr || wr_op == OP_MCLR) ? '0 : tc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tc_q <= '0;
        end else begin
            tc_q <= tc_base | tc_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wr_op == OP_MCLR) begin
            req_q <= '0;
        end else if (wr_op == OP_REQ) begin
            req_q[sel.ch] <= sel.set;
        end
    end

    AST_TC_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        (|tc_in) |=> ((tc_q & $past(tc_in)) == $past(tc_in))); // R13

    AST_RDCLR_KEEPS_REQ: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && wr_op == OP_NONE) |=> $stable(req_q)); // R11

    AST_RDCLR_DROPS_TC: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && tc_in == '0) |=> (tc_q == '0)); // R11

endmodule

// File: rtl/dmac_ctl_bank.sv
module dmac_ctl_bank
    import dmac_ctl_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter int          PORT_SHIFT = 1,
    parameter logic [7:0]  CMD_REJECT = 8'hF0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic                     rd_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    input  logic [NUM_CH-1:0]        tc_pulse,
    input  logic                     ff_toggle,
    output logic [NUM_CH-1:0]        chan_mask,
    output logic                     reeval,
    output logic [7:0]               cmd_q,
    output logic [NUM_CH*MODE_W-1:0] mode_q,
    output logic                     ptr_ff
);

    localparam int STAT_W = 2 * NUM_CH;

    wr_op_e            wr_op;
    rd_op_e            rd_op;
    chan_sel_t         sel;
    logic [STAT_W-1:0] status;
    logic              cmd_ok;

    assign sel    = chan_sel(wdata);
    assign cmd_ok = (wdata == 8'h00) || ((wdata & CMD_REJECT) == 8'h00);

    dmac_port_decode #(.ADDR_W(ADDR_W), .PORT_SHIFT(PORT_SHIFT)) u_dec (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wr_op (wr_op),
        .rd_op (rd_op)
    );

    dmac_mask_reg #(.CH(NUM_CH)) u_mask (
        .clk    (clk),
        .rst    (rst),
        .wr_op  (wr_op),
        .sel    (sel),
        .load   (wdata[NUM_CH-1:0]),
        .mask_q (chan_mask)
    );

    dmac_status_reg #(.CH(NUM_CH)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .wr_op    (wr_op),
        .sel      (sel),
        .rd_clr   (rd_op == RD_STATUS),
        .tc_in    (tc_pulse),
        .status_q (status)
    );

    always_ff @(posedge clk) begin
        if (rst || wr_op == OP_MCLR) begin
            cmd_q <= '0;
        end else if (wr_op == OP_CMD && cmd_ok) begin
            cmd_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || wr_op == OP_MCLR || wr_op == OP_CLRFF) begin
            ptr_ff <= 1'b0;
        end else if (ff_toggle) begin
            ptr_ff <= ~ptr_ff;
        end
    end

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
            always_ff @(posedge clk) begin
                if (rst) begin
                    mode_q[c*MODE_W +: MODE_W] <= '0;
                end else if (wr_op == OP_MODE && sel.ch == 2'(c)) begin
                    mode_q[c*MODE_W +: MODE_W] <= wdata[7:8-MODE_W];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            reeval <= 1'b0;
        end else begin
            reeval <= wakes_arbiter(wr_op);
        end
    end

    always_comb begin
        case (rd_op)
            RD_STATUS: rdata = status;
            RD_MASK:   rdata = {{(8-NUM_CH){1'b0}}, chan_mask};
            default:   rdata = 8'hFF;
        endcase
    end

    AST_CMD_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_op == OP_CMD && wdata != 8'h00 && (wdata & CMD_REJECT) != 8'h00)
        |=> $stable(cmd_q)); // R3

    AST_REEVAL_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        reeval |-> $past(wr_en)); // R10

    AST_HIGH_IDX_NO_EFFECT: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_op == OP_NONE) |=> ($stable(chan_mask) && $stable(cmd_q) && !reeval)); // R2

    AST_FFCLR_WINS: assert property (@(posedge clk) disable iff (rst)
        (wr_op == OP_CLRFF) |=> !ptr_ff); // R7

endmodule

// File: tb/tb_dmac_ctl_bank.sv
`timescale 1ns/1ps
module tb_dmac_ctl_bank;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [7:0]  wdata = 8'h00;
    logic [7:0]  rdata;
    logic [3:0]  tc_pulse = 4'h0;
    logic        ff_toggle = 1'b0;
    logic [3:0]  chan_mask;
    logic        reeval;
    logic [7:0]  cmd_q;
    logic [23:0] mode_q;
    logic        ptr_ff;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    dmac_ctl_bank dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tc_pulse(tc_pulse), .ff_toggle(ff_toggle),
        .chan_mask(chan_mask), .reeval(reeval), .cmd_q(cmd_q), .mode_q(mode_q),
        .ptr_ff(ptr_ff)
    );

    localparam int S_RDATA = 0, S_MASK = 1, S_CMD = 2, S_PTR = 3, S_REEVAL = 4, S_MODE = 5;

    typedef struct {
        string      req;
        int         sel;
        logic [7:0] exp;
    } item_t;

    item_t sb_q[$];
    event  mon_ev;

    function automatic logic [7:0] observe(input int sel);
        case (sel)
            S_RDATA:  return rdata;
            S_MASK:   return {4'h0, chan_mask};
            S_CMD:    return cmd_q;
            S_PTR:    return {7'h0, ptr_ff};
            S_REEVAL: return {7'h0, reeval};
            default:  return {2'b00, mode_q[(sel-S_MODE)*6 +: 6]};
        endcase
    endfunction

    initial begin
        forever begin
            @(mon_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = sb_q.pop_front();
                act = observe(it.sel);
                vectors++;
                if (act !== it.exp) begin
                    miscompares++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input string req, input int sel, input logic [7:0] exp);
        item_t it;
        it.req = req; it.sel = sel; it.exp = exp;
        sb_q.push_back(it);
        ->mon_ev;
        #1;
    endtask

    function automatic logic [7:0] A(input int idx);
        return 8'(idx << 1);
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1;
        expect_val(req, S_RDATA, exp);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        expect_val("R1 mask", S_MASK, 8'h0F);
        expect_val("R1 cmd", S_CMD, 8'h00);
        expect_val("R1 ptr", S_PTR, 8'h00);
        expect_val("R1 reeval", S_REEVAL, 8'h00);
        expect_val("R1 mode2", S_MODE + 2, 8'h00);
        rd("R1 R11 status", A(0), 8'h00);
        rd("R1 R12 mask read", A(1), 8'h0F);

        // R3 command
        wr(A(0), 8'h0C);
        expect_val("R3 accept", S_CMD, 8'h0C);
        expect_val("R10 no pulse on cmd", S_REEVAL, 8'h00);
        wr(A(0), 8'h1C);
        expect_val("R3 reject", S_CMD, 8'h0C);
        wr(A(0), 8'h00);
        expect_val("R3 zero", S_CMD, 8'h00);

        // R5 single mask, R10 pulse
        wr(A(2), 8'h01);
        expect_val("R5 clear ch1", S_MASK, 8'h0D);
        expect_val("R10 pulse", S_REEVAL, 8'h01);
        idle();
        expect_val("R10 one cycle", S_REEVAL, 8'h00);
        wr(A(2), 8'h06);
        expect_val("R5 set set ch2", S_MASK, 8'h0D);
        wr(A(2), 8'h02);
        expect_val("R5 clear ch2", S_MASK, 8'h09);

        // R2 decode
        wr(8'h05, 8'h00);
        expect_val("R2 low bit ignored", S_MASK, 8'h08);
        wr(A(9), 8'hFF);
        expect_val("R2 idx9 mask", S_MASK, 8'h08);
        expect_val("R2 idx9 cmd", S_CMD, 8'h00);
        expect_val("R2 idx9 no reeval", S_REEVAL, 8'h00);

        // R9 all masks
        wr(A(6), 8'h3C);
        expect_val("R9 clear all", S_MASK, 8'h00);
        expect_val("R10 clrall pulse", S_REEVAL, 8'h01);
        wr(A(7), 8'hA5);
        expect_val("R9 load all", S_MASK, 8'h05);
        rd("R12 mask read", A(1), 8'h05);

        // R4 requests
        wr(A(1), 8'h05);
        expect_val("R10 req pulse", S_REEVAL, 8'h01);
        wr(8'h22, 8'h07);
        rd("R4 R2 two requests", A(0), 8'hA0);
        wr(A(1), 8'h01);
        rd("R4 clear ch1", A(0), 8'h80);

        // R13 / R11 terminal count
        @(negedge clk); tc_pulse = 4'b0100;
        @(negedge clk); tc_pulse = 4'b0000;
        rd("R13 tc set", A(0), 8'h84);
        rd("R11 low cleared", A(0), 8'h80);
        @(negedge clk);
        tc_pulse = 4'b0001; rd_en = 1'b1; addr = A(0);
        #1;
        expect_val("R11 read old", S_RDATA, 8'h80);
        @(negedge clk);
        tc_pulse = 4'b0000; rd_en = 1'b0;
        rd("R13 set wins", A(0), 8'h81);
        rd("R11 cleared again", A(0), 8'h80);

        // R6 modes
        wr(A(3), 8'hB6);
        expect_val("R6 mode2", S_MODE + 2, 8'h2D);
        expect_val("R6 mode0 kept", S_MODE + 0, 8'h00);
        wr(A(3), 8'hFD);
        expect_val("R6 mode1", S_MODE + 1, 8'h3F);
        expect_val("R6 mode2 kept", S_MODE + 2, 8'h2D);

        // R7 flip-flop
        @(negedge clk); ff_toggle = 1'b1;
        @(negedge clk); ff_toggle = 1'b0;
        expect_val("R7 toggle", S_PTR, 8'h01);
        wr(A(4), 8'h55);
        expect_val("R7 clear", S_PTR, 8'h00);
        expect_val("R10 no pulse ffclr", S_REEVAL, 8'h00);
        @(negedge clk); ff_toggle = 1'b1; wr_en = 1'b1; addr = A(4); wdata = 8'h00;
        @(negedge clk); ff_toggle = 1'b0; wr_en = 1'b0;
        expect_val("R7 clear beats toggle", S_PTR, 8'h00);
        @(negedge clk); ff_toggle = 1'b1;
        @(negedge clk); ff_toggle = 1'b0;

        // R8 master clear
        wr(A(0), 8'h0C);
        wr(A(5), 8'h00);
        expect_val("R8 mask", S_MASK, 8'h0F);
        expect_val("R8 cmd", S_CMD, 8'h00);
        expect_val("R8 ptr", S_PTR, 8'h00);
        expect_val("R10 mclr pulse", S_REEVAL, 8'h01);
        rd("R8 status", A(0), 8'h00);

        // R12 open reads
        rd("R12 idx2", A(2), 8'hFF);
        rd("R12 idx9", A(9), 8'hFF);

        idle();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule